// File: doc/BRIEF.md
# Burst-of-Four Separate-Port SRAM Core

This block is a synthesizable memory with one write port and one read port that work on their own. Each port takes a command that carries a base address. It then moves a burst of four 18-bit words. The pins that would run at double data rate are modelled as two words per clock cycle: an early word and a late word, each on its own single-rate bus. Every port action is decided on the rising edge of `clk`.

A write command is accepted on an edge where `wr_sel_n` is low. The four data words arrive as early/late pairs on the next two edges. Each word has its own active-low byte-lane enables. A read command is accepted on an edge where `rd_sel_n` is low. The four stored words appear as early/late pairs in the two cycles after the following two edges, and `rd_oe` marks those cycles. While `rd_oe` is low the read buses are treated as high-impedance and carry zero.

Each port needs two cycles for a burst. A port therefore accepts a new command at most on every other edge. A new burst may start on the edge that carries the last data pair of the current one.

Top module: `sep_burst_sram`

## Requirements
- R1: While `rst` is high and after it is released, `rd_oe` is low, `rd_q_early` and `rd_q_late` are zero, and no write is pending.
- R2: On an edge where both selects are high (1) and no burst is in progress, the write data and write enables are ignored. `rd_oe` stays low, and the read buses are zero whenever `rd_oe` is low.
- R3: `wr_sel_n` low at edge t captures `wr_addr`. The early and late words sampled at edge t+1 are stored at burst offsets 0 and 1. Those sampled at edge t+2 are stored at offsets 2 and 3.
- R4: `rd_sel_n` low at edge t captures `rd_addr`. After edge t+1, `rd_q_early`/`rd_q_late` hold the words at offsets 0 and 1. After edge t+2, they hold the words at offsets 2 and 3. `rd_oe` is high in exactly those two cycles for an isolated read.
- R5: A burst address is the captured address with bits [1:0] replaced by the offset. The offsets are used in the order 00, 01, 10, 11, whatever the low bits of the command address were.
- R6: A read command on the edge right after an accepted read is ignored. Its address is never used.
- R7: `wr_sel_n` on the edge right after an accepted write is ignored. No burst is started and its address is never used.
- R8: The write enables are active low, two bits per word. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. A lane whose bit is 1 keeps its old contents. With both bits 1, that word is left untouched.
- R9: Enables are sampled per word and per edge. The early enables apply to the early word and the late enables to the late word. They may differ between the two pairs of one burst.
- R10: A read and a write can be accepted on the same edge and run independently. A read fetch that happens on the same edge as a write to that word returns the contents from before that edge.
- R11: Either port accepts a new command on edge t+2 of its previous burst. For reads this keeps `rd_oe` high with no gap between the bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_sel_n | input | 1 | Write command select, active low |
| wr_addr | input | ADDR_W | Write burst address |
| wr_d_early | input | 18 | First data word of a pair (offset 0 or 2) |
| wr_d_late | input | 18 | Second data word of a pair (offset 1 or 3) |
| wr_bw_early_n | input | 2 | Lane enables for the early word, active low |
| wr_bw_late_n | input | 2 | Lane enables for the late word, active low |
| rd_sel_n | input | 1 | Read command select, active low |
| rd_addr | input | ADDR_W | Read burst address |
| rd_q_early | output | 18 | First word of the current read pair |
| rd_q_late | output | 18 | Second word of the current read pair |
| rd_oe | output | 1 | Read data valid; low means the outputs are high-impedance |

## Verification
A write data pair and a read fetch of the same word can land on the same clock edge. The bench provokes this in two ways: it issues a read and a write to one base address on a single edge, and it runs long stretches of random interleaved commands. A behavioural model applies the fetch before that edge's write. The read words are then compared every cycle against the pre-write contents, so an array that lets a write pass through to a same-edge read shows up as a data mismatch.

// File: rtl/sb4_pkg.sv
package sb4_pkg;
    localparam int DATA_W = 18;
    localparam int LANE_W = 9;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int BURST  = 4;
    localparam int BEAT_W = $clog2(BURST);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef struct packed {
        word_t early;
        word_t late;
    } pair_t;

    // Burst offset of a word: pair index in the high bit, early/late in the low bit.
    function automatic logic [BEAT_W-1:0] beat_offset(phase_e ph, logic late);
        return {ph == PH_SECOND, late};
    endfunction
endpackage

// File: rtl/sb4_wr_port.sv
module sb4_wr_port
    import sb4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  pair_t             din,
    input  lane_mask_t        be_early_n,
    input  lane_mask_t        be_late_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr_early,
    output logic [ADDR_W-1:0] addr_late,
    output pair_t             wdata,
    output lane_mask_t        lane_we_early,
    output lane_mask_t        lane_we_late
);
    localparam int HI_W = ADDR_W - BEAT_W;

    phase_e          phase_q;
    logic [HI_W-1:0] base_q;
    logic            accept;

    // The select is a don't-care while the first data pair is due.
    assign accept = !sel_n && (phase_q != PH_FIRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            base_q  <= '0;
        end else begin
            if (phase_q == PH_FIRST) phase_q <= PH_SECOND;
            else if (accept)         phase_q <= PH_FIRST;
            else                     phase_q <= PH_IDLE;
            if (accept) base_q <= cmd_addr[ADDR_W-1:BEAT_W];
        end
    end

    assign wr_en         = (phase_q != PH_IDLE);
    assign addr_early    = {base_q, beat_offset(phase_q, 1'b0)};
    assign addr_late     = {base_q, beat_offset(phase_q, 1'b1)};
    assign wdata         = din;
    assign lane_we_early = wr_en ? ~be_early_n : '0;
    assign lane_we_late  = wr_en ? ~be_late_n  : '0;

    // R3: the second data pair always follows the first.
    p_wr_second_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FIRST) |=> (phase_q == PH_SECOND));

    // R7: a select during the first data pair leaves the burst base alone.
    p_wr_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FIRST) |=> $stable(base_q));
endmodule

// File: rtl/sb4_rd_port.sv
module sb4_rd_port
    import sb4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  word_t             word_early,
    input  word_t             word_late,
    output logic [ADDR_W-1:0] fetch_early,
    output logic [ADDR_W-1:0] fetch_late,
    output pair_t             q,
    output logic              oe
);
    localparam int HI_W = ADDR_W - BEAT_W;

    phase_e          phase_q;
    logic [HI_W-1:0] base_q;
    logic            accept;

    // A read on the edge right after an accepted read is dropped.
    assign accept = !sel_n && (phase_q != PH_FIRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            base_q  <= '0;
            q       <= '0;
            oe      <= 1'b0;
        end else begin
            if (phase_q == PH_FIRST) phase_q <= PH_SECOND;
            else if (accept)         phase_q <= PH_FIRST;
            else                     phase_q <= PH_IDLE;
            if (accept) base_q <= cmd_addr[ADDR_W-1:BEAT_W];
            if (phase_q != PH_IDLE) begin
                q  <= '{early: word_early, late: word_late};
                oe <= 1'b1;
            end else begin
                q  <= '0;
                oe <= 1'b0;
            end
        end
    end

    assign fetch_early = {base_q, beat_offset(phase_q, 1'b0)};
    assign fetch_late  = {base_q, beat_offset(phase_q, 1'b1)};

    // R6: a second read select in the busy slot does not move the base.
    p_rd_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FIRST) |=> $stable(base_q));

    // R4: once valid data starts, it lasts for at least a second cycle.
    p_rd_two_pairs_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |=> oe);
endmodule

// File: rtl/sb4_array.sv
module sb4_array
    import sb4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr_early,
    input  logic [ADDR_W-1:0] wr_addr_late,
    input  pair_t             wdata,
    input  lane_mask_t        lane_we_early,
    input  lane_mask_t        lane_we_late,
    input  logic [ADDR_W-1:0] rd_addr_early,
    input  logic [ADDR_W-1:0] rd_addr_late,
    output word_t             rd_word_early,
    output word_t             rd_word_late
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we_early[l])
                    mem[wr_addr_early][l*LANE_W +: LANE_W] <= wdata.early[l*LANE_W +: LANE_W];
                if (lane_we_late[l])
                    mem[wr_addr_late][l*LANE_W +: LANE_W] <= wdata.late[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_word_early = mem[rd_addr_early];
    assign rd_word_late  = mem[rd_addr_late];

    // R5: the two words of one pair always sit in distinct, adjacent slots.
    always_comb begin
        if (wr_en) begin
            a_pair_adjacent_r5: assert ((wr_addr_early ^ wr_addr_late) == ADDR_W'(1));
        end
    end
endmodule

// File: rtl/sep_burst_sram.sv
module sep_burst_sram
    import sb4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_d_early,
    input  logic [DATA_W-1:0] wr_d_late,
    input  logic [LANES-1:0]  wr_bw_early_n,
    input  logic [LANES-1:0]  wr_bw_late_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q_early,
    output logic [DATA_W-1:0] rd_q_late,
    output logic              rd_oe
);
    logic              w_en;
    logic [ADDR_W-1:0] w_addr_e, w_addr_l, r_addr_e, r_addr_l;
    pair_t             w_data, r_q;
    lane_mask_t        w_we_e, w_we_l;
    word_t             r_word_e, r_word_l;

    sb4_wr_port #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .sel_n(wr_sel_n), .cmd_addr(wr_addr),
        .din('{early: wr_d_early, late: wr_d_late}),
        .be_early_n(wr_bw_early_n), .be_late_n(wr_bw_late_n),
        .wr_en(w_en), .addr_early(w_addr_e), .addr_late(w_addr_l),
        .wdata(w_data), .lane_we_early(w_we_e), .lane_we_late(w_we_l)
    );

    sb4_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_en(w_en), .wr_addr_early(w_addr_e), .wr_addr_late(w_addr_l),
        .wdata(w_data), .lane_we_early(w_we_e), .lane_we_late(w_we_l),
        .rd_addr_early(r_addr_e), .rd_addr_late(r_addr_l),
        .rd_word_early(r_word_e), .rd_word_late(r_word_l)
    );

    sb4_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .sel_n(rd_sel_n), .cmd_addr(rd_addr),
        .word_early(r_word_e), .word_late(r_word_l),
        .fetch_early(r_addr_e), .fetch_late(r_addr_l),
        .q(r_q), .oe(rd_oe)
    );

    assign rd_q_early = r_q.early;
    assign rd_q_late  = r_q.late;

    // R2: outside a valid window the read buses are quiet.
    p_rd_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> (rd_q_early == '0 && rd_q_late == '0));
endmodule

// File: tb/sep_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sep_burst_sram_tb_top;
    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_sel_n = 1'b1, rd_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [17:0]   wr_d_early = '0, wr_d_late = '0;
    logic [1:0]    wr_bw_early_n = 2'b11, wr_bw_late_n = 2'b11;
    logic [17:0]   rd_q_early, rd_q_late;
    logic          rd_oe;

    always #2 clk = ~clk;

    sep_burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
        .wr_d_early(wr_d_early), .wr_d_late(wr_d_late),
        .wr_bw_early_n(wr_bw_early_n), .wr_bw_late_n(wr_bw_late_n),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .rd_q_early(rd_q_early), .rd_q_late(rd_q_late), .rd_oe(rd_oe)
    );

    // Behavioural reference model
    logic [17:0] m_mem [N];
    int          r_ph = 0, w_ph = 0, r_base = 0, w_base = 0;
    logic        e_oe = 1'b0;
    logic [17:0] e_qe = '0, e_ql = '0;
    bit          armed = 0;
    int          n_checks = 0, n_fail = 0;
    string       cur_req = "R1";
    bit          done = 0;

    function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] d, logic [1:0] be_n);
        logic [17:0] r = old;
        if (!be_n[0]) r[8:0]  = d[8:0];
        if (!be_n[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    always @(posedge clk) begin
        int off, nr, nw;
        armed = 1;
        if (rst) begin
            r_ph = 0; w_ph = 0; e_oe = 0; e_qe = '0; e_ql = '0;
        end else begin
            // read fetch first: sees contents before this edge's write
            if (r_ph != 0) begin
                off  = (r_ph == 2) ? 2 : 0;
                e_qe = m_mem[r_base + off];
                e_ql = m_mem[r_base + off + 1];
                e_oe = 1;
            end else begin
                e_oe = 0; e_qe = '0; e_ql = '0;
            end
            nr = (r_ph == 1) ? 2 : 0;
            if (!rd_sel_n && r_ph != 1) begin nr = 1; r_base = int'(rd_addr) & ~3; end
            r_ph = nr;
            if (w_ph != 0) begin
                off = (w_ph == 2) ? 2 : 0;
                m_mem[w_base + off]     = merge(m_mem[w_base + off], wr_d_early, wr_bw_early_n);
                m_mem[w_base + off + 1] = merge(m_mem[w_base + off + 1], wr_d_late, wr_bw_late_n);
            end
            nw = (w_ph == 1) ? 2 : 0;
            if (!wr_sel_n && w_ph != 1) begin nw = 1; w_base = int'(wr_addr) & ~3; end
            w_ph = nw;
        end
    end

    task automatic check(string what, logic [17:0] act, logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            check("rd_oe", {17'd0, rd_oe}, {17'd0, e_oe});
            check("rd_q_early", rd_q_early, e_qe);
            check("rd_q_late", rd_q_late, e_ql);
        end
    end

    task automatic step(logic ws, logic [AW-1:0] wa, logic [17:0] de, logic [17:0] dl,
                        logic [1:0] be, logic [1:0] bl, logic rs, logic [AW-1:0] ra);
        @(negedge clk);
        wr_sel_n = ws; wr_addr = wa; wr_d_early = de; wr_d_late = dl;
        wr_bw_early_n = be; wr_bw_late_n = bl; rd_sel_n = rs; rd_addr = ra;
    endtask

    task automatic idle();
        step(1, '0, 18'($urandom), 18'($urandom), 2'b00, 2'b00, 1, '0);
    endtask

    task automatic rd_burst(logic [AW-1:0] a);
        step(1, '0, '0, '0, 2'b11, 2'b11, 0, a);
        idle(); idle();
    endtask

    task automatic wr_burst(logic [AW-1:0] a, logic [1:0] b0, logic [1:0] b1,
                            logic [1:0] b2, logic [1:0] b3);
        step(0, a, '0, '0, 2'b11, 2'b11, 1, '0);
        step(1, '0, 18'($urandom), 18'($urandom), b0, b1, 1, '0);
        step(1, '0, 18'($urandom), 18'($urandom), b2, b3, 1, '0);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) idle();
        @(negedge clk); rst = 0;
        idle(); idle();

        cur_req = "R3";
        for (int b = 0; b < N / 4; b++) wr_burst(AW'(b * 4), 2'b00, 2'b00, 2'b00, 2'b00);
        idle();

        cur_req = "R2";
        repeat (8) idle();

        cur_req = "R4";
        for (int b = 0; b < N / 4; b++) rd_burst(AW'(b * 4));

        cur_req = "R5";
        wr_burst(6'h17, 2'b00, 2'b00, 2'b00, 2'b00);
        rd_burst(6'h16);
        rd_burst(6'h13);

        cur_req = "R8";
        wr_burst(6'h20, 2'b10, 2'b01, 2'b11, 2'b11);
        rd_burst(6'h20);

        cur_req = "R9";
        wr_burst(6'h24, 2'b01, 2'b10, 2'b10, 2'b00);
        rd_burst(6'h24);

        cur_req = "R6";
        step(1, '0, '0, '0, 2'b11, 2'b11, 0, 6'h08);
        step(1, '0, '0, '0, 2'b11, 2'b11, 0, 6'h28);
        idle(); idle();
        rd_burst(6'h28);

        cur_req = "R7";
        step(0, 6'h0C, '0, '0, 2'b11, 2'b11, 1, '0);
        step(0, 6'h30, 18'h3ABCD, 18'h12345, 2'b00, 2'b00, 1, '0);
        step(1, '0, 18'h2AAAA, 18'h15555, 2'b00, 2'b00, 1, '0);
        step(1, '0, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, 1, '0);
        idle();
        rd_burst(6'h30);
        rd_burst(6'h0C);

        cur_req = "R10";
        step(0, 6'h14, '0, '0, 2'b11, 2'b11, 0, 6'h14);
        step(1, '0, 18'h11111, 18'h22222, 2'b00, 2'b00, 1, '0);
        step(1, '0, 18'h33333, 18'h04444, 2'b00, 2'b00, 1, '0);
        rd_burst(6'h14);

        cur_req = "R11";
        for (int i = 0; i < 6; i++) begin
            step(0, AW'(i * 4), 18'($urandom), 18'($urandom), 2'b00, 2'b00, 0, AW'(60 - i * 4));
            step(1, '0, 18'($urandom), 18'($urandom), 2'b00, 2'b00, 1, '0);
        end
        idle(); idle(); idle();
        for (int i = 0; i < 600; i++)
            step(1'($urandom), AW'($urandom), 18'($urandom), 18'($urandom),
                 2'($urandom), 2'($urandom), 1'($urandom), AW'($urandom));
        idle(); idle(); idle();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule